// File: doc/BRIEF.md
# Paired-Engine Lane Mask Controller

This block holds the per-lane execution mask for two vector engines that are bound to a single instruction stream. Both engines always issue the same instruction in the same cycle. Engine 0 owns the lower half of the lanes and engine 1 owns the upper half. Because neither engine may fetch an instruction of its own, any disagreement between the halves of the pair is resolved only by disabling lanes. This holds even when each half is uniform within itself. An engine with no live lane sits idle while its partner executes.

Every issued instruction carries an execution width, a power of two from 1 to the full lane count, and an opcode. The opcode is a plain operation or one of three structured control-flow markers: open-conditional, switch-to-alternative and close-conditional. A conditional evaluates a per-lane condition vector. The controller saves the enclosing mask on a stack and narrows the live set. On the alternative marker it flips the live set against the saved mask. On the close marker it restores the saved mask. When no lane within the width would run a branch body, the controller raises a branch-skip so that fetch can jump past that body. A saturating counter records every issued instruction that ran with part of its width disabled.

The controller is a two-state machine. In state ST_RUN it tracks masks. The transition RUN_TO_FAULT happens when an open-conditional arrives while the stack is full. State ST_FAULT is sticky, and only reset leaves it, through the transition FAULT_TO_RUN. The RUN_HOLD transition keeps ST_RUN on every other input.

Top module: `lmask_ctrl`

## Requirements
- R1: A lane whose index is at or above 2^width_log2 is never active on act_lo/act_hi, whatever the mask. A width_log2 value of 5 or above means all 32 lanes. Lane i of the pair is act_lo[i] for i<16 and act_hi[i-16] otherwise.
- R2: After reset the mask has all lanes set, the stack is empty, div_count is 0 and fault is 0.
- R3: Opcode 1 (open-conditional) saves the current mask on the stack and sets the mask to the current mask AND cond.
- R4: Opcode 2 (alternative) sets the mask to the saved mask AND NOT the current mask. With an empty stack it changes nothing.
- R5: Opcode 3 (close) restores the saved mask and removes it from the stack. With an empty stack it changes nothing. Opcode 0 (plain) never changes the mask.
- R6: br_skip is 1 during an issued opcode 1 when mask AND cond AND width is zero. It is 1 during an issued opcode 2 when saved AND NOT mask AND width is zero. It is 0 in every other case.
- R7: skip is 1 exactly when no lane of the pair is active for the presented width.
- R8: eng_idle[0] is 1 when act_lo is all zero, and eng_idle[1] is 1 when act_hi is all zero. The two halves always follow the same instruction, so a 32-wide branch that splits the halves runs both bodies.
- R9: div_count adds one for each issued instruction in which at least one lane inside its width is inactive. It is registered, so the new value appears after the clock edge, and it saturates at its maximum.
- R10: An open-conditional with 8 entries already stacked sets fault. Fault then stays set until reset. While fault is set, both act outputs are zero, skip is 1, br_skip is 0, and the mask, stack and counter do not change.
- R11: With issue_valid low, the mask, stack and counter keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction issues this cycle |
| op | input | 2 | 0 plain, 1 open-conditional, 2 alternative, 3 close |
| width_log2 | input | 3 | log2 of the execution width |
| cond | input | 32 | Per-lane branch condition |
| act_lo | output | 16 | Active lanes of engine 0 |
| act_hi | output | 16 | Active lanes of engine 1 |
| skip | output | 1 | No lane of the pair is active |
| br_skip | output | 1 | Fetch may jump past the branch body |
| eng_idle | output | 2 | Per-engine no-active-lane flags |
| fault | output | 1 | Sticky stack overflow |
| div_count | output | 16 | Saturating count of partly masked instructions |

## Verification
Condition vectors are chosen to separate the cases of interest:
- An all-ones condition tells uniform flow, which needs one body and no counter step, apart from divergence.
- An all-zero condition shows the branch-skip on the taken side.
- A condition of ones only in the lower sixteen lanes is uniform inside each engine but splits the pair. It must still run both bodies and count divergence.
- A checkerboard nested under that split shows that the stack composes masks.

A width sweep from one lane to 32 lanes separates width masking from branch masking, and a 16-wide instruction must idle engine 1. Further runs cover a ninth nested conditional, inputs that change while issue_valid is low, close markers on an empty stack, and a long divergent run that reaches counter saturation.

// File: rtl/lmask_pkg.sv
package lmask_pkg;
    typedef enum logic [1:0] {
        OP_PLAIN = 2'd0,
        OP_IF    = 2'd1,
        OP_ELSE  = 2'd2,
        OP_ENDIF = 2'd3
    } op_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_FAULT = 1'b1
    } st_e;
endpackage

// File: rtl/lmask_width.sv
module lmask_width #(
    parameter int LANES = 32,
    parameter int WL_W  = 3
) (
    input  logic [WL_W-1:0]  wl,
    output logic [LANES-1:0] wm
);
    localparam int MAXL = $clog2(LANES);

    // One enable per lane: full width when wl reaches log2(LANES)
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign wm[i] = (32'(wl) >= MAXL) ? 1'b1 : (i < (32'd1 << wl));
    end
endmodule

// File: rtl/lmask_stack.sv
module lmask_stack #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] ptr;
    logic [PW-1:0] ptr_m1;

    assign ptr_m1 = ptr - PW'(1);
    assign empty  = (ptr == '0);
    assign full   = (ptr == PW'(DEPTH));
    assign top    = empty ? '0 : mem[ptr_m1[AW-1:0]];

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (push && !full)
            ptr <= ptr + PW'(1);
        else if (pop && !empty)
            ptr <= ptr_m1;
    end

    always_ff @(posedge clk) begin
        if (push && !full)
            mem[ptr[AW-1:0]] <= din;
    end

    AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(ptr) <= DEPTH); // R10
    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !empty) |=> (ptr == $past(ptr) - PW'(1))); // R5
endmodule

// File: rtl/lmask_divcnt.sv
module lmask_divcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (inc && (cnt != '1))
            cnt <= cnt + W'(1);
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt)); // R9
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && (cnt != '1)) |=> (cnt == $past(cnt) + W'(1))); // R9
endmodule

// File: rtl/lmask_ctrl.sv
module lmask_ctrl
    import lmask_pkg::*;
#(
    parameter int HALF  = 16,
    parameter int DEPTH = 8,
    parameter int CNT_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           issue_valid,
    input  logic [1:0]                     op,
    input  logic [$clog2($clog2(2*HALF)+1)-1:0] width_log2,
    input  logic [2*HALF-1:0]              cond,
    output logic [HALF-1:0]                act_lo,
    output logic [HALF-1:0]                act_hi,
    output logic                           skip,
    output logic                           br_skip,
    output logic [1:0]                     eng_idle,
    output logic                           fault,
    output logic [CNT_W-1:0]               div_count
);
    localparam int LANES = 2 * HALF;
    localparam int WL_W  = $clog2($clog2(LANES) + 1);

    st_e              state_q, state_d;
    op_e              op_i;
    logic [LANES-1:0] mask_q, mask_d;
    logic [LANES-1:0] wm, eff, act_all, top;
    logic             stk_empty, stk_full, push, pop, cnt_inc;

    assign op_i = op_e'(op);

    lmask_width #(.LANES(LANES), .WL_W(WL_W)) i_width (
        .wl (width_log2),
        .wm (wm)
    );

    lmask_stack #(.W(LANES), .DEPTH(DEPTH)) i_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (mask_q),
        .top   (top),
        .empty (stk_empty),
        .full  (stk_full)
    );

    lmask_divcnt #(.W(CNT_W)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (cnt_inc),
        .cnt   (div_count)
    );

    assign eff = mask_q & wm;

    // State register (FAULT_TO_RUN only through reset)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            mask_q  <= '1;
        end else begin
            state_q <= state_d;
            mask_q  <= mask_d;
        end
    end

    // Next state, mask update and outputs
    always_comb begin
        state_d = state_q;
        mask_d  = mask_q;
        push    = 1'b0;
        pop     = 1'b0;
        cnt_inc = 1'b0;
        act_all = '0;
        br_skip = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                act_all = eff;
                if (issue_valid) begin
                    cnt_inc = (eff != wm);
                    unique case (op_i)
                        OP_PLAIN: ;
                        OP_IF: begin
                            br_skip = ~|(mask_q & cond & wm);
                            if (stk_full) begin
                                state_d = ST_FAULT;      // RUN_TO_FAULT
                            end else begin
                                push   = 1'b1;
                                mask_d = mask_q & cond;
                            end
                        end
                        OP_ELSE: begin
                            if (!stk_empty) begin
                                br_skip = ~|(top & ~mask_q & wm);
                                mask_d  = top & ~mask_q;
                            end
                        end
                        OP_ENDIF: begin
                            if (!stk_empty) begin
                                pop    = 1'b1;
                                mask_d = top;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_FAULT: begin
                act_all = '0;
            end
            default: ;
        endcase
    end

    assign act_lo      = act_all[HALF-1:0];
    assign act_hi      = act_all[LANES-1:HALF];
    assign skip        = ~|act_all;
    assign eng_idle[0] = ~|act_lo;
    assign eng_idle[1] = ~|act_hi;
    assign fault       = (state_q == ST_FAULT);

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault); // R10
    AST_FAULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> ($stable(mask_q) && $stable(div_count))); // R10
    AST_IDLE_ON_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> (eng_idle == 2'b11)); // R7
    AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (width_log2 == '0) |-> ((act_hi == '0) && (act_lo[HALF-1:1] == '0))); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> ($stable(mask_q) && $stable(div_count))); // R11
    AST_BRSKIP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        br_skip |-> (issue_valid && (op == 2'd1 || op == 2'd2))); // R6
endmodule

// File: tb/test_lmask_ctrl.sv
module test_lmask_ctrl;
    localparam int CLK_P = 10;
    localparam int DEPTH = 8;
    localparam int CNT_W = 8;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [2:0]  width_log2 = 3'd5;
    logic [31:0] cond = '0;
    logic [15:0] act_lo, act_hi;
    logic        skip, br_skip, fault;
    logic [1:0]  eng_idle;
    logic [CNT_W-1:0] div_count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_mask;
    logic [31:0] m_stk[$];
    int          m_cnt;
    bit          m_fault;

    always #(CLK_P/2) clk = ~clk;

    lmask_ctrl #(.HALF(16), .DEPTH(DEPTH), .CNT_W(CNT_W)) i_lmask_ctrl (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .op(op),
        .width_log2(width_log2), .cond(cond), .act_lo(act_lo), .act_hi(act_hi),
        .skip(skip), .br_skip(br_skip), .eng_idle(eng_idle), .fault(fault),
        .div_count(div_count)
    );

    function automatic logic [31:0] wmask(int w);
        if (w >= 5) return '1;
        return (32'h1 << (1 << w)) - 32'h1;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] a, input logic [31:0] e);
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, a, e);
        end
    endtask

    task automatic step(input bit v, input logic [1:0] o, input int w,
                        input logic [31:0] c, input string req);
        logic [31:0] wm, eff;
        bit e_br;
        @(negedge clk);
        issue_valid = v; op = o; width_log2 = 3'(w); cond = c;
        #1;
        wm  = wmask(w);
        eff = m_fault ? 32'h0 : (m_mask & wm);
        e_br = 0;
        if (!m_fault && v) begin
            if (o == 2'd1) e_br = ((m_mask & c & wm) == 0);
            else if (o == 2'd2 && m_stk.size() > 0)
                e_br = ((m_stk[$] & ~m_mask & wm) == 0);
        end
        check(req, "act", {act_hi, act_lo}, eff);
        check(req, "skip", 32'(skip), 32'(eff == 0));
        check(req, "br_skip", 32'(br_skip), 32'(e_br));
        check(req, "eng_idle", 32'(eng_idle), {30'd0, eff[31:16] == 0, eff[15:0] == 0});
        check(req, "fault", 32'(fault), 32'(m_fault));
        check(req, "div_count", 32'(div_count), 32'(m_cnt));
        @(posedge clk);
        if (!m_fault && v) begin
            if (eff != wm && m_cnt < CMAX) m_cnt++;
            case (o)
                2'd1: if (m_stk.size() == DEPTH) m_fault = 1;
                      else begin m_stk.push_back(m_mask); m_mask = m_mask & c; end
                2'd2: if (m_stk.size() > 0) m_mask = m_stk[$] & ~m_mask;
                2'd3: if (m_stk.size() > 0) m_mask = m_stk.pop_back();
                default: ;
            endcase
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; issue_valid = 1'b0;
        repeat (3) @(posedge clk);
        m_mask = '1; m_stk.delete(); m_cnt = 0; m_fault = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        for (int k = 0; k < 100000; k++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        step(0, 2'd0, 5, 32'h0, "R2");
        // R1: width sweep, full mask, no divergence counted
        for (int w = 0; w < 8; w++) step(1, 2'd0, w, 32'h0, "R1");
        // R8: 16-wide instruction idles engine 1
        step(1, 2'd0, 4, 32'h0, "R8");
        // R3/R8: halves uniform internally but split across the pair
        step(1, 2'd1, 5, 32'h0000FFFF, "R3");
        step(1, 2'd0, 5, 32'h0, "R8");
        step(1, 2'd0, 5, 32'h0, "R9");
        // nested checkerboard inside the split
        step(1, 2'd1, 5, 32'h55555555, "R3");
        step(1, 2'd0, 3, 32'h0, "R1");
        step(1, 2'd2, 5, 32'h0, "R4");
        step(1, 2'd3, 5, 32'h0, "R5");
        step(1, 2'd2, 5, 32'h0, "R4");
        step(1, 2'd0, 5, 32'h0, "R8");
        step(1, 2'd3, 5, 32'h0, "R5");
        // R11: inputs move while issue_valid is low
        step(0, 2'd1, 5, 32'h0, "R11");
        step(0, 2'd3, 2, 32'hFFFF0000, "R11");
        step(1, 2'd0, 5, 32'h0, "R11");
        // uniform taken: alternative body is skipped
        step(1, 2'd1, 5, 32'hFFFFFFFF, "R6");
        step(1, 2'd2, 5, 32'h0, "R6");
        step(1, 2'd0, 5, 32'h0, "R7");
        step(1, 2'd3, 5, 32'h0, "R5");
        // uniform not taken: body skipped, empty pair
        step(1, 2'd1, 2, 32'h0, "R6");
        step(1, 2'd0, 5, 32'h0, "R7");
        step(1, 2'd2, 5, 32'h0, "R6");
        step(1, 2'd3, 5, 32'h0, "R5");
        // close and alternative on an empty stack
        step(1, 2'd3, 5, 32'h0, "R5");
        step(1, 2'd2, 5, 32'h0, "R4");
        step(1, 2'd0, 5, 32'h0, "R5");
        // R9: saturation under sustained divergence
        step(1, 2'd1, 5, 32'h00000001, "R9");
        for (int k = 0; k < 300; k++) step(1, 2'd0, 5, 32'h0, "R9");
        step(1, 2'd3, 5, 32'h0, "R9");
        // R10: ninth nested conditional overflows
        do_reset();
        step(0, 2'd0, 5, 32'h0, "R2");
        for (int k = 0; k < 9; k++) step(1, 2'd1, 5, 32'hFFFFFFFF, "R10");
        step(1, 2'd0, 5, 32'h0, "R10");
        step(1, 2'd2, 5, 32'h0, "R10");
        step(1, 2'd3, 5, 32'h0, "R10");
        step(1, 2'd1, 5, 32'h0, "R10");
        do_reset();
        step(1, 2'd0, 5, 32'h0, "R2");
        step(1, 2'd3, 5, 32'h0, "R2");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule